// File: doc/BRIEF.md
# Ternary Bipolar Line-Code Encoder

This block turns a serial stream of data bits into a three-level line code for an external level shifter. The line output is a small signed code meaning +1, 0 or -1. The block runs from a clock at twice the bit rate, so every bit occupies two clock cycles, called the first half and the second half. Bits arrive through a valid/ready handshake. The encoder takes a new bit only when the bit period on the line is finishing or the line is idle, so a sender that holds valid high produces a gap-free stream.

Two encodings can be selected. The mode is captured with each bit, so the mode may change on any bit boundary.

- In the return-to-zero bipolar encoding, a one pulses positive and a zero pulses negative. Both pulses occupy only the first half of the bit, and the second half of every bit returns to zero.
- In the alternate mark inversion encoding, a zero stays at zero for the whole bit. Each one is sent at the polarity opposite to the previous one. That polarity is kept across any number of zeros, idle cycles and bits of the other encoding.

Top module: `tern_line_encoder`

## Requirements
- R1: The line output uses a two's-complement code: 2'b01 is +1, 2'b00 is zero and 2'b11 is -1. The value 2'b10 never appears.
- R2: `in_ready` is high when the line is idle or shows the second half of a bit. A bit is taken at the rising edge where `in_valid` and `in_ready` are both high. Its first half appears on the line in the next cycle and its second half in the cycle after that.
- R3: In return-to-zero bipolar mode (`mode_sel` = 0), a one drives +1 during the first half of its bit.
- R4: In return-to-zero bipolar mode, a zero drives -1 during the first half of its bit.
- R5: In return-to-zero bipolar mode, the second half of every bit is zero.
- R6: In alternate mark inversion mode (`mode_sel` = 1), a zero drives zero during both halves.
- R7: In alternate mark inversion mode, a one drives the same nonzero level in both halves. That level is opposite to the level of the previous alternate-mark-inversion one, whatever lies between them. Over any run with an even number of ones, the output sums to zero.
- R8: The first alternate-mark-inversion one after reset is +1.
- R9: When no bit is being sent, the output is zero and the alternate-mark-inversion polarity does not change.
- R10: The mode is sampled when a bit is taken. Changing `mode_sel` during a bit does not alter that bit. Bits sent in return-to-zero bipolar mode do not move the alternate-mark-inversion polarity.
- R11: While `rst_n` is low at a clock edge, the next state is idle. The output is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0 selects return-to-zero bipolar, 1 selects alternate mark inversion |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | The offered data bit |
| in_ready | output | 1 | The encoder can take a bit at this edge |
| line_code | output | CODE_W | Signed line level: +1, 0 or -1 |

## Verification
The outputs are driven only from registers. A bit taken at edge k shows its first half after edge k and its second half after edge k+1. `in_ready` then rises, so an offered bit can be taken at edge k+2. The bench changes inputs just after a rising edge and samples outputs at the falling edge. A behavioural queue model holds the two expected half-levels of each accepted bit and pops one per cycle. The line output and `in_ready` are compared with this model in every cycle. Separate tallies check the alternating polarity of marks and the zero sum of an even-mark run.

// File: rtl/tern_pkg.sv
// Package: shared types for the ternary line encoder.
// Assumes: one mode bit; encoders of more modes would widen the enum.
package tern_pkg;

    // Line encoding selected per bit
    typedef enum logic {
        MODE_RZB = 1'b0,
        MODE_AMI = 1'b1
    } tern_mode_e;

    // Contents of the bit slot currently on the line
    typedef struct packed {
        logic       busy;   // a bit is being sent
        logic       half;   // 0: first half, 1: second half
        logic       data;   // the bit being sent
        tern_mode_e mode;   // encoding captured with the bit
    } tern_slot_t;

endpackage

// File: rtl/tern_phase_ctrl.sv
// Module: tern_phase_ctrl
// Accepts bits through valid/ready and steps each one through two
// half-periods of the double-rate clock.
// Assumes: clk runs at twice the bit rate; rst_n is synchronous, active low.
module tern_phase_ctrl
    import tern_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output logic       take,
    output tern_slot_t slot
);

    // Ready when idle or the current bit is in its last half
    always_comb begin
        in_ready = !slot.busy || slot.half;
        take     = in_valid && in_ready;
    end

    // Slot sequencing: load on take, first half -> second half -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '{busy: 1'b0, half: 1'b0, data: 1'b0, mode: MODE_RZB};
        end else if (take) begin
            slot.busy <= 1'b1;
            slot.half <= 1'b0;
            slot.data <= in_bit;
            slot.mode <= tern_mode_e'(mode_sel);
        end else if (slot.busy && !slot.half) begin
            slot.half <= 1'b1;
        end else begin
            slot.busy <= 1'b0;
            slot.half <= 1'b0;
        end
    end

    // R2: a first half is always followed by a second half
    p_half_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && !slot.half) |=> (slot.busy && slot.half));

    // R2: no bit can be taken during a first half
    p_no_take_first_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && !slot.half) |-> !in_ready);

    // R10: the captured mode does not move inside a bit
    p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && !slot.half) |=> $stable(slot.mode));

endmodule

// File: rtl/tern_ami_polarity.sv
// Module: tern_ami_polarity
// Keeps the sign for the next alternate-mark-inversion mark and latches
// the sign for the mark now on the line.
// Assumes: take/mode/bit are the values presented at the accepting edge.
module tern_ami_polarity
    import tern_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic mode_sel,
    input  logic in_bit,
    output logic mark_neg
);

    logic next_neg;
    logic mark_take;

    // An AMI one consumes one polarity step
    always_comb mark_take = take && (tern_mode_e'(mode_sel) == MODE_AMI) && in_bit;

    // Polarity state: start positive, flip on every AMI mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_neg <= 1'b0;
            mark_neg <= 1'b0;
        end else if (mark_take) begin
            mark_neg <= next_neg;
            next_neg <= !next_neg;
        end
    end

    // R7: each AMI mark moves the polarity
    p_flip_on_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mark_take |=> (next_neg != $past(next_neg)));

    // R9, R10: anything else leaves the polarity alone
    p_hold_otherwise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mark_take |=> $stable(next_neg));

endmodule

// File: rtl/tern_level_map.sv
// Module: tern_level_map
// Maps the slot on the line and the mark sign to a signed line code.
// Assumes: CODE_W >= 2; the code is two's complement of +1, 0, -1.
module tern_level_map
    import tern_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tern_slot_t        slot,
    input  logic              mark_neg,
    output logic [CODE_W-1:0] line_code
);

    localparam logic [CODE_W-1:0] LVL_POS  = CODE_W'(1);
    localparam logic [CODE_W-1:0] LVL_ZERO = '0;
    localparam logic [CODE_W-1:0] LVL_NEG  = '1;

    // Level selection per mode and half
    always_comb begin
        line_code = LVL_ZERO;
        if (slot.busy) begin
            if (slot.mode == MODE_RZB) begin
                if (!slot.half) line_code = slot.data ? LVL_POS : LVL_NEG;
            end else if (slot.data) begin
                line_code = mark_neg ? LVL_NEG : LVL_POS;
            end
        end
    end

    // R1: only the three legal codes appear
    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_code == LVL_POS) || (line_code == LVL_ZERO) || (line_code == LVL_NEG));

    // R9: idle line is zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot.busy |-> (line_code == LVL_ZERO));

    // R5: return-to-zero bipolar second half is zero
    p_rz_second_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && slot.half && slot.mode == MODE_RZB) |-> (line_code == LVL_ZERO));

endmodule

// File: rtl/tern_line_encoder.sv
// Module: tern_line_encoder (top)
// Three-level line encoder with return-to-zero bipolar and alternate mark
// inversion modes, fed one bit per two clocks through valid/ready.
// Assumes: clk at twice the bit rate; synchronous active-low reset.
module tern_line_encoder
    import tern_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              in_ready,
    output logic [CODE_W-1:0] line_code
);

    tern_slot_t slot;
    logic       take;
    logic       mark_neg;

    tern_phase_ctrl u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .take     (take),
        .slot     (slot)
    );

    tern_ami_polarity u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .mode_sel (mode_sel),
        .in_bit   (in_bit),
        .mark_neg (mark_neg)
    );

    tern_level_map #(.CODE_W(CODE_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .mark_neg  (mark_neg),
        .line_code (line_code)
    );

    // R7: an AMI bit keeps its level through the second half
    p_ami_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && !slot.half && slot.mode == MODE_AMI) |=> $stable(line_code));

    // R6: an AMI zero is zero on the line
    p_ami_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.busy && slot.mode == MODE_AMI && !slot.data) |-> (line_code == '0));

endmodule

// File: tb/tb_tern_line_encoder.sv
module tb_tern_line_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready;
    logic [1:0] line_code;

    tern_line_encoder #(.CODE_W(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .line_code (line_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R11";
    int    exp_q[$];
    int    next_pol = 1;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    tally_on = 1'b0;
    int    tally_sum = 0;
    int    last_mark = 0;

    function automatic int lvl(input logic [1:0] c);
        return int'($signed(c));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model and comparison, once per cycle at the falling edge
    always @(negedge clk) begin
        int cur;
        bit acc;
        cycles++;
        if (!done) begin
            cur = (exp_q.size() > 0) ? exp_q[0] : 0;
            check(tag, lvl(line_code), cur);
            check("R2", int'(in_ready), (exp_q.size() <= 1) ? 1 : 0);
            if (line_code == 2'b10) check("R1", 1, 0);
            if (tally_on) begin
                tally_sum += lvl(line_code);
                if (!in_ready && lvl(line_code) != 0) begin
                    if (last_mark != 0) check("R7", lvl(line_code), -last_mark);
                    last_mark = lvl(line_code);
                end
            end
            acc = in_valid && (exp_q.size() <= 1) && rst_n;
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (!rst_n) begin
                exp_q.delete();
                next_pol = 1;
            end else if (acc) begin
                if (!mode_sel) begin
                    exp_q.push_back(in_bit ? 1 : -1);
                    exp_q.push_back(0);
                end else if (in_bit) begin
                    exp_q.push_back(next_pol);
                    exp_q.push_back(next_pol);
                    next_pol = -next_pol;
                end else begin
                    exp_q.push_back(0);
                    exp_q.push_back(0);
                end
            end
            if (cycles > WATCHDOG) begin
                check("watchdog", 1, 0);
                done = 1'b1;
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    task automatic send(input logic m, input logic b);
        mode_sel = m;
        in_bit   = b;
        in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        // R11: reset state
        tag = "R11";
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);

        // R3, R4, R5: return-to-zero bipolar, back to back and with gaps
        tag = "R3 R4 R5";
        send(0, 1); send(0, 0); send(0, 1); send(0, 1); send(0, 0);
        idle(3);
        send(0, 0); idle(2); send(0, 1);
        idle(3);

        // R6, R7, R8: AMI run with an even number of ones
        tag = "R6 R7 R8";
        tally_on = 1'b1; tally_sum = 0; last_mark = 0;
        send(1, 0); send(1, 1); send(1, 0); send(1, 0); send(1, 1);
        send(1, 1); send(1, 0); send(1, 1);
        idle(3);
        tally_on = 1'b0;
        check("R7", tally_sum, 0);

        // R9: idle gap keeps polarity (next mark +1)
        tag = "R9";
        idle(7);
        send(1, 1);
        idle(4);

        // R10: RZ bits between marks, mode change mid-bit
        tag = "R10";
        send(0, 1); send(0, 0);
        send(1, 1);
        mode_sel = 1'b0;
        idle(1);
        send(1, 1);
        mode_sel = 1'b1;
        idle(1);
        send(0, 1);
        idle(3);

        // R8: reset mid-stream restores positive first mark
        tag = "R8";
        send(1, 1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        send(1, 1); send(1, 1);
        idle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule